// File: doc/BRIEF.md
# Write-Busy Status Bit Generator

This block sits on the read return path of a nonvolatile memory model. It shows software that an internal write is still in progress by changing two bits of the word being read. A one-cycle start pulse, marked as a word program or as an erase, arms a busy timer. The timer's length comes from a parameter for each kind of operation. While the timer runs, a read of the addressed word does not return the word unchanged. The polling bit (bit 7) is inverted for a program and held at zero for an erase. The toggle bit (bit 6) changes value on every read. Once the timer expires, reads return the stored word exactly as it is, and the block accepts a new start.

The stored word comes in on `mem_word`. Reads arrive as a one-cycle `rd_req` strobe, and each read produces a response beat on `rsp_valid`/`rsp_data` one clock later. There is no back-pressure on this path. The consumer must take every response beat in the cycle it appears. `rd_req` may be high on every cycle, and each high cycle is one read.

Top module: `wr_status_gen`

## Requirements
- R1: While a program is busy, a read returns bit 7 as the inverse of `mem_word[7]`, and all bits other than 7 and 6 equal `mem_word`.
- R2: While an erase is busy, a read returns bit 7 as 0, and all bits other than 7 and 6 equal `mem_word`.
- R3: While busy, bit 6 of a read equals the toggle state, and each read made while busy inverts that state for the next read.
- R4: A start seen at a clock edge while idle raises `busy` at that edge. `busy` then stays high for exactly PROG_CYCLES clock cycles (`op_erase`=0) or ERASE_CYCLES clock cycles (`op_erase`=1).
- R5: A start pulse that arrives while `busy` is high neither lengthens nor restarts the running operation.
- R6: While idle, a read returns `mem_word` on all bits, and reads made while idle leave the toggle state unchanged.
- R7: Each cycle with `rd_req` high produces exactly one `rsp_valid` beat on the following cycle. No beat appears without a request.
- R8: After reset, `busy` and `rsp_valid` are 0 and the toggle state is 0.
- R9: The kind of operation is captured at the start pulse. Changing `op_erase` while busy does not change how bit 7 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins an internal write |
| op_erase | input | 1 | Kind of write, sampled with `start`: 1 = erase, 0 = program |
| mem_word | input | DATA_W | True contents of the location being read |
| rd_req | input | 1 | Read strobe, one read per high cycle |
| rsp_valid | output | 1 | Response beat, one cycle after `rd_req` |
| rsp_data | output | DATA_W | Read word with the status bits applied |
| busy | output | 1 | High while the internal write runs |

## Verification
Assertions check on every cycle the rules that hold from one clock to the next:
- the bit 7 override for each kind of operation,
- pass-through of all bits while idle,
- the toggle state flipping on each busy read and holding while idle,
- the one-cycle response latency,
- busy staying high until the count runs out, and start pulses having no effect while busy.

Only the bench scenarios can show the exact busy length for each kind of operation, the alternating sequence of bit 6 across many reads, and the reset value of the toggle state. They also show that changing `op_erase` mid-operation has no visible effect, which is judged against an independent cycle model.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } wop_e;

  // bit positions whose meaning software relies on
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
endpackage

// File: rtl/wr_busy_timer.sv
module wr_busy_timer
  import wr_status_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic erase_i,
  output logic busy_o,
  output wop_e op_o
);
  localparam int unsigned MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LD_P = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] LD_E = CNT_W'(ERASE_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  wop_e             op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_PROG;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == 1) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= erase_i ? LD_E : LD_P;
      op_q   <= erase_i ? OP_ERASE : OP_PROG;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;

  a_r4_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_i) |=> busy_q);
  a_r4_holds_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != 1) |=> busy_q);
  a_r5_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> (cnt_q == $past(cnt_q) - 1'b1) && (op_q == $past(op_q)));
endmodule

// File: rtl/wr_toggle_reg.sv
module wr_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                tog_q <= 1'b0;
    else if (busy_i && rd_i)   tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  a_r3_flip_per_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_i) |=> (tog_q != $past(tog_q)));
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i) |=> $stable(tog_q));
endmodule

// File: rtl/wr_status_overlay.sv
module wr_status_overlay
  import wr_status_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              busy_i,
  input  wop_e              op_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] word_o
);
  always_comb begin
    word_o = word_i;
    if (busy_i) begin
      word_o[POLL_BIT] = (op_i == OP_ERASE) ? 1'b0 : ~word_i[POLL_BIT];
      word_o[TOG_BIT]  = tog_i;
    end
  end
endmodule

// File: rtl/wr_rsp_stage.sv
module wr_rsp_stage #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) data_o <= data_i;
    end
  end

  a_r7_beat_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);
  a_r7_no_spurious_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o);
endmodule

// File: rtl/wr_status_gen.sv
module wr_status_gen
  import wr_status_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] mem_word,
  input  logic              rd_req,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy
);
  wop_e              op_w;
  logic              tog_w;
  logic [DATA_W-1:0] view_w;

  wr_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .erase_i(op_erase),
    .busy_o(busy), .op_o(op_w));

  wr_toggle_reg u_tog (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .rd_i(rd_req), .tog_o(tog_w));

  wr_status_overlay #(.DATA_W(DATA_W)) u_ovl (
    .busy_i(busy), .op_i(op_w), .tog_i(tog_w), .word_i(mem_word), .word_o(view_w));

  wr_rsp_stage #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .req_i(rd_req), .data_i(view_w),
    .vld_o(rsp_valid), .data_o(rsp_data));

  a_r6_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy) |=> (rsp_data == $past(mem_word)));
  a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy && op_w == OP_PROG) |=> (rsp_data[POLL_BIT] == ~$past(mem_word[POLL_BIT])));
  a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy && op_w == OP_ERASE) |=> (rsp_data[POLL_BIT] == 1'b0));
endmodule

// File: tb/tb_wr_status_gen.sv
module tb_wr_status_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int PC = 6;
  localparam int EC = 15;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_erase = 1'b0;
  logic [DW-1:0] mem_word = '0;
  logic rd_req = 1'b0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct {
    logic [DW-1:0] data;
    string t7;
    string t6;
  } exp_t;
  exp_t sb[$];

  // independent reference state
  logic m_busy = 1'b0, m_erase = 1'b0, m_tog = 1'b0, m_ign = 1'b0;
  int   m_cnt = 0;

  wr_status_gen #(.DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .mem_word(mem_word), .rd_req(rd_req), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model and scoreboard producer
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_erase = 0; m_tog = 0; m_ign = 0; m_cnt = 0;
    end else begin
      if (rd_req) begin
        exp_t it;
        it.data = mem_word;
        if (m_busy) begin
          it.data[7] = m_erase ? 1'b0 : ~mem_word[7];
          it.data[6] = m_tog;
          it.t7 = (op_erase != m_erase) ? "R9" : (m_erase ? "R2" : "R1");
          it.t6 = "R3";
        end else begin
          it.t7 = "R6";
          it.t6 = "R6";
        end
        sb.push_back(it);
        m_tog = m_tog ^ m_busy;
      end
      if (m_busy) begin
        if (start) m_ign = 1;
        if (m_cnt == 1) m_busy = 0;
        m_cnt--;
      end else if (start) begin
        m_busy = 1; m_erase = op_erase; m_ign = 0;
        m_cnt = op_erase ? EC : PC;
      end
    end
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, m_ign ? "R5 busy" : "R4 busy", DW'(busy), DW'(m_busy));
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_valid == 1'b1, "R7 missing beat", DW'(rsp_valid), DW'(1));
        chk(rsp_data[7] == e.data[7], {e.t7, " bit7"}, rsp_data, e.data);
        chk(rsp_data[6] == e.data[6], {e.t6, " bit6"}, rsp_data, e.data);
        chk({rsp_data[DW-1:8], rsp_data[5:0]} == {e.data[DW-1:8], e.data[5:0]},
            {e.t7 == "R9" ? "R2" : e.t7, " other bits"}, rsp_data, e.data);
      end else begin
        chk(rsp_valid == 1'b0, "R7 spurious beat", DW'(rsp_valid), DW'(0));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick(input logic er);
    start = 1'b1; op_erase = er;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic reads(input int n, input logic [DW-1:0] w);
    mem_word = w;
    rd_req = 1'b1;
    step(n);
    rd_req = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R8: reset state
    chk(busy == 1'b0, "R8 busy", DW'(busy), DW'(0));
    chk(rsp_valid == 1'b0, "R8 rsp_valid", DW'(rsp_valid), DW'(0));
    step(1);
    // R6: idle pass-through for several patterns
    reads(1, 16'hA5C3); reads(1, 16'h00FF); reads(1, 16'hFFFF); step(2);
    // R1 + R3 (+R8 toggle starts at 0): program with back-to-back reads
    kick(1'b0);
    reads(4, 16'h1280);
    step(PC + 2);
    reads(2, 16'h3C7E);      // idle after program, toggle must not move
    // R2: erase, with idle reads before and after
    kick(1'b1);
    reads(3, 16'hFF00);
    step(2);
    reads(2, 16'hFFFF);
    step(EC + 2);
    reads(1, 16'hFFFF);
    // R5: repeated start pulses while busy
    kick(1'b0);
    step(2);
    kick(1'b1);
    reads(1, 16'h0040);
    kick(1'b0);
    step(PC + 3);
    // R9: change op_erase mid-erase
    kick(1'b1);
    op_erase = 1'b0;
    reads(3, 16'h00C0);
    step(EC + 2);
    // start coinciding with a read: that read sees the idle word
    mem_word = 16'h5A5A; rd_req = 1'b1; start = 1'b1; op_erase = 1'b0;
    step(1);
    start = 1'b0;
    step(1);
    rd_req = 1'b0;
    step(PC + 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule